// File: doc/BRIEF.md
# Circular Command Ring Controller

A 4096-byte ring of 32-bit command words that sits between a host and a command consumer. The host can place words anywhere in the ring through a memory-style write port. Those words stay hidden from the consumer until the host publishes a new write pointer. As an alternative, the host can stream words through an append port. That port stores each word at the write pointer and moves the pointer forward by itself, as long as the free-space count allows. Offsets are in bytes and every command word is aligned to 4 bytes, so the two lowest offset bits of every pointer and address are dropped.

The consumer side offers one word at a time through a valid/ready pair and advances the read pointer by 4 on each accepted word. The block also keeps an output-entry index for the consumer. A consumed start-of-list word resets the index, and each emit pulse from the consumer raises it by one. Asking for more entries than the limit allows is a fault, and so is an explicit fault request from the consumer. A fault parks the read pointer at all ones and stops the consumer. Only a host clear recovers the block.

Top module: `cmdq_ring`

## Requirements
- R1: After reset both pointers are 0, free space is 4092, the output index is 0, the fault and overflow flags are low and no word is offered to the consumer.
- R2: A memory-port write stores its word at byte offset `mem_addr` with the two low bits dropped. The consumer does not see it until the host writes the write pointer. A write-pointer update also drops the two low bits.
- R3: The consumer is offered the word at the read pointer whenever the pointers differ. Each accepted word moves the read pointer up by 4, wrapping from 4092 to 0. Nothing is offered when the pointers are equal.
- R4: Free space equals 4092 minus ((write − read) mod 4096), so a full ring reads 0 and an empty ring reads 4092.
- R5: An append-port write stores its word at the write pointer and moves the write pointer up by 4, wrapping from 4092 to 0. The word is then visible to the consumer.
- R6: An append-port write that arrives when free space is 0 is dropped. The write pointer does not change, and a sticky overflow flag is set that stays set until a host clear.
- R7: When the consumer accepts the word equal to the start code (default 0xFFFF_FF00), the output index goes to 0. Each emit pulse otherwise raises the index by one, and the index never goes above the limit of 2048.
- R8: An emit pulse while the output index already equals 2048 raises the fault.
- R9: An asserted fault request also raises the fault. While faulted, the read pointer reads 0xFFF, free space reads 0 and no word is offered.
- R10: A host clear sets both pointers and the output index to 0 and drops the fault and overflow flags. It takes priority over every other input in the same cycle.
- R11: When a write-pointer update and an append write arrive in the same cycle, the update wins and the append write is discarded without setting overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_clr | input | 1 | Synchronous clear of pointers, index and flags |
| mem_we | input | 1 | Memory-port write strobe |
| mem_addr | input | 12 | Memory-port byte offset |
| mem_wdata | input | 32 | Memory-port word |
| wp_we | input | 1 | Write-pointer update strobe |
| wp_wdata | input | 12 | New write pointer, byte offset |
| bulk_we | input | 1 | Append-port write strobe |
| bulk_wdata | input | 32 | Append-port word |
| rd_ptr | output | 12 | Read pointer, byte offset |
| wr_ptr | output | 12 | Write pointer, byte offset |
| free_bytes | output | 12 | Free space in bytes |
| ovf_flag | output | 1 | Sticky append overflow flag |
| fault | output | 1 | Fault flag |
| pop_valid | output | 1 | A word is offered to the consumer |
| pop_data | output | 32 | Offered word |
| pop_ready | input | 1 | Consumer accepts the offered word |
| emit | input | 1 | Consumer produced one output entry |
| out_idx | output | 12 | Output-entry index |
| flt_req | input | 1 | Consumer fault request |

## Verification
A read pointer that moves wrongly shows up at once as a word offered out of order, or a word offered twice or skipped. The bench compares every accepted word against the expected order in the same cycle it is taken, so such a fault is reported within one pop. A wrong pointer difference first shows in the free-space output, one cycle after the pointer write. A wrong wrap only shows after 1023 appends, which is why the bench fills the ring completely and drains it across the top. Errors in the fault and index state show at the read pointer and the index one cycle after the emit pulse that crosses the limit.

// File: rtl/cmdq_ring.sv
module cmdq_ring #(
  parameter int          BYTES    = 4096,
  parameter int          OUT_MAX  = 2048,
  parameter logic [31:0] START_OP = 32'hFFFF_FF00
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_clr,
  input  logic                          mem_we,
  input  logic [$clog2(BYTES)-1:0]      mem_addr,
  input  logic [31:0]                   mem_wdata,
  input  logic                          wp_we,
  input  logic [$clog2(BYTES)-1:0]      wp_wdata,
  input  logic                          bulk_we,
  input  logic [31:0]                   bulk_wdata,
  output logic [$clog2(BYTES)-1:0]      rd_ptr,
  output logic [$clog2(BYTES)-1:0]      wr_ptr,
  output logic [$clog2(BYTES)-1:0]      free_bytes,
  output logic                          ovf_flag,
  output logic                          fault,
  output logic                          pop_valid,
  output logic [31:0]                   pop_data,
  input  logic                          pop_ready,
  input  logic                          emit,
  output logic [$clog2(OUT_MAX+1)-1:0]  out_idx,
  input  logic                          flt_req
);
  localparam int AW    = $clog2(BYTES);
  localparam int WORDS = BYTES / 4;
  localparam int IW    = $clog2(OUT_MAX + 1);
  localparam logic [AW-1:0] CAP  = AW'(BYTES - 4);
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [IW-1:0] LIM  = IW'(OUT_MAX);

  logic [31:0]   ram [WORDS];
  logic [AW-1:0] used;
  logic          pop_fire, is_start, bulk_ok, bulk_full, emit_ovf, fault_set;

  assign used       = wr_ptr - rd_ptr;
  assign free_bytes = fault ? '0 : CAP - used;
  assign pop_valid  = (rd_ptr != wr_ptr) && !fault;
  assign pop_data   = ram[rd_ptr[AW-1:2]];
  assign pop_fire   = pop_valid && pop_ready;
  assign is_start   = pop_fire && (pop_data == START_OP);
  assign bulk_ok    = bulk_we && !wp_we && (free_bytes != '0);
  assign bulk_full  = bulk_we && !wp_we && (free_bytes == '0);
  assign emit_ovf   = emit && !is_start && (out_idx == LIM);
  assign fault_set  = !fault && (flt_req || emit_ovf);

  always_ff @(posedge clk) begin
    if (mem_we)  ram[mem_addr[AW-1:2]] <= mem_wdata;
    if (bulk_ok) ram[wr_ptr[AW-1:2]]   <= bulk_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      ovf_flag <= 1'b0;
      fault    <= 1'b0;
      out_idx  <= '0;
    end else if (host_clr) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      ovf_flag <= 1'b0;
      fault    <= 1'b0;
      out_idx  <= '0;
    end else begin
      if (fault_set)     rd_ptr <= '1;
      else if (pop_fire) rd_ptr <= rd_ptr + STEP;
      if (fault_set) fault <= 1'b1;
      if (wp_we)        wr_ptr <= {wp_wdata[AW-1:2], 2'b00};
      else if (bulk_ok) wr_ptr <= wr_ptr + STEP;
      if (bulk_full) ovf_flag <= 1'b1;
      if (is_start)                   out_idx <= '0;
      else if (emit && out_idx < LIM) out_idx <= out_idx + 1'b1;
    end
  end

  // R2
  wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr[1:0] == 2'b00);

  // R3
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !host_clr && !fault_set) |=> rd_ptr == $past(rd_ptr + STEP));

  // R6
  bulk_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_full && !host_clr) |=> (ovf_flag && $stable(wr_ptr)));

  // R7
  start_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_start && !host_clr) |=> out_idx == '0);

  // R7
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_idx <= LIM);

  // R8
  emit_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_ovf && !host_clr) |=> fault);

  // R9
  fault_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> rd_ptr == '1);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> (rd_ptr == '0 && wr_ptr == '0 && !fault && !ovf_flag));
endmodule

// File: tb/cmdq_ring_tb_top.sv
module cmdq_ring_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] START = 32'hFFFF_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_clr = 1'b0, mem_we = 1'b0, wp_we = 1'b0, bulk_we = 1'b0;
  logic [11:0] mem_addr = '0, wp_wdata = '0;
  logic [31:0] mem_wdata = '0, bulk_wdata = '0;
  logic [11:0] rd_ptr, wr_ptr, free_bytes, out_idx;
  logic        ovf_flag, fault, pop_valid, pop_ready = 1'b0, emit = 1'b0, flt_req = 1'b0;
  logic [31:0] pop_data;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_ring dut_i (
    .clk(clk), .rst_n(rst_n), .host_clr(host_clr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wp_we(wp_we), .wp_wdata(wp_wdata),
    .bulk_we(bulk_we), .bulk_wdata(bulk_wdata),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .free_bytes(free_bytes),
    .ovf_flag(ovf_flag), .fault(fault),
    .pop_valid(pop_valid), .pop_data(pop_data), .pop_ready(pop_ready),
    .emit(emit), .out_idx(out_idx), .flt_req(flt_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic mem_put(input logic [11:0] a, input logic [31:0] d);
    tick(); mem_we = 1'b1; mem_addr = a; mem_wdata = d; exp_q.push_back(d);
    tick(); mem_we = 1'b0;
  endtask

  task automatic wp_put(input logic [11:0] p);
    tick(); wp_we = 1'b1; wp_wdata = p;
    tick(); wp_we = 1'b0;
  endtask

  task automatic bulk_put(input int n, input logic [31:0] base, input bit track);
    for (int k = 0; k < n; k++) begin
      tick(); bulk_we = 1'b1; bulk_wdata = base + k;
      if (track) exp_q.push_back(base + k);
    end
    tick(); bulk_we = 1'b0;
  endtask

  task automatic clear_host();
    tick(); host_clr = 1'b1;
    tick(); host_clr = 1'b0;
  endtask

  task automatic emit_n(input int n);
    for (int k = 0; k < n; k++) begin
      tick(); emit = 1'b1;
    end
    tick(); emit = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 5000 && exp_q.size() != 0; k++) tick();
    tick();
  endtask

  // monitor: compares every accepted word against the scoreboard (R3, R5)
  always @(negedge clk) begin
    if (rst_n && pop_valid && pop_ready) begin
      if (exp_q.size() == 0) check("R3 unexpected pop", pop_data, 32'hDEAD_BEEF);
      else check("R3 R5 pop order", pop_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd", rd_ptr, 0);
    check("R1 wr", wr_ptr, 0);
    check("R1 free", free_bytes, 4092);
    check("R1 flags", {ovf_flag, fault, pop_valid}, 0);
    check("R1 idx", out_idx, 0);

    pop_ready = 1'b1;
    mem_put(12'd0, 32'hA0A0_0001);
    mem_put(12'd4, 32'hA0A0_0002);
    mem_put(12'd9, 32'hA0A0_0003);
    @(negedge clk);
    check("R2 hidden", pop_valid, 0);
    check("R2 wr unchanged", wr_ptr, 0);
    pop_ready = 1'b0;
    wp_put(12'd13);
    @(negedge clk);
    check("R2 wp align", wr_ptr, 12);
    check("R4 free", free_bytes, 4080);
    check("R2 visible", pop_valid, 1);
    pop_ready = 1'b1;
    drain();
    @(negedge clk);
    check("R3 rd after drain", rd_ptr, 12);
    check("R3 empty", pop_valid, 0);
    check("R4 free empty", free_bytes, 4092);

    clear_host();
    pop_ready = 1'b0;
    bulk_put(1023, 32'h1000_0000, 1'b1);
    @(negedge clk);
    check("R5 wr full", wr_ptr, 4092);
    check("R4 free full", free_bytes, 0);
    check("R6 no ovf yet", ovf_flag, 0);
    bulk_put(1, 32'h5555_5555, 1'b0);
    @(negedge clk);
    check("R6 ovf set", ovf_flag, 1);
    check("R6 wr held", wr_ptr, 4092);
    pop_ready = 1'b1;
    drain();
    @(negedge clk);
    check("R3 rd top", rd_ptr, 4092);
    pop_ready = 1'b0;
    bulk_put(2, 32'h2000_0000, 1'b1);
    @(negedge clk);
    check("R5 wr wrap", wr_ptr, 4);
    check("R4 free wrap", free_bytes, 4084);
    pop_ready = 1'b1;
    drain();
    @(negedge clk);
    check("R3 rd wrap", rd_ptr, 4);
    check("R6 ovf sticky", ovf_flag, 1);

    clear_host();
    @(negedge clk);
    check("R10 ptrs", {rd_ptr, wr_ptr}, 0);
    check("R10 ovf", ovf_flag, 0);
    pop_ready = 1'b0;
    bulk_put(1, START, 1'b1);
    emit_n(5);
    @(negedge clk);
    check("R7 count", out_idx, 5);
    pop_ready = 1'b1;
    drain();
    @(negedge clk);
    check("R7 start clears", out_idx, 0);

    emit_n(2048);
    @(negedge clk);
    check("R8 at limit", out_idx, 2048);
    check("R8 no fault yet", fault, 0);
    emit_n(1);
    @(negedge clk);
    check("R8 fault", fault, 1);
    check("R9 rd parked", rd_ptr, 12'hFFF);
    check("R9 free zero", free_bytes, 0);
    check("R9 no pop", pop_valid, 0);
    check("R7 idx capped", out_idx, 2048);
    clear_host();
    @(negedge clk);
    check("R10 fault cleared", fault, 0);
    check("R10 rd", rd_ptr, 0);
    check("R10 idx", out_idx, 0);

    pop_ready = 1'b0;
    bulk_put(2, 32'h3000_0000, 1'b0);
    tick(); flt_req = 1'b1;
    tick(); flt_req = 1'b0;
    @(negedge clk);
    check("R9 req fault", fault, 1);
    check("R9 req rd", rd_ptr, 12'hFFF);
    pop_ready = 1'b1;
    repeat (4) tick();
    @(negedge clk);
    check("R9 still parked", rd_ptr, 12'hFFF);
    pop_ready = 1'b0;
    clear_host();

    tick(); wp_we = 1'b1; wp_wdata = 12'd8; bulk_we = 1'b1; bulk_wdata = 32'h7777_7777;
    tick(); wp_we = 1'b0; bulk_we = 1'b0;
    @(negedge clk);
    check("R11 wp wins", wr_ptr, 8);
    check("R11 no ovf", ovf_flag, 0);
    check("R3 R5 queue empty", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule